// File: doc/BRIEF.md
# Packed Calendar Clock Counter

This block keeps wall-clock time in broken-down form rather than as a linear seconds count. A single 32-bit word holds the second, minute, hour, weekday, day of month and month fields. A separate 16-bit register holds the year as four BCD digits, century in the upper byte. Each pulse on a one-second strobe input advances the time by one second. All fields roll over inside the block: month lengths, leap Februaries and the decimal carry of the year are all handled there.

Software uses a simple synchronous register port. Each word has a live value, a load value and a match value. The year load value is only staged when written. The following write of the time load word moves both staged values into the counter on the same edge. An alarm flag rises when the full date and time, weekday included, first equals the match pair. Writing a one to bit 0 of a clear location drops the flag.

Top module: `packed_calendar_clock`

## Requirements
- R1: After reset the time word reads 0x021E0000 (2000-01-01 00:00:00, weekday 7 = Saturday), the year reads 0x2000, the control word reads 0 and the alarm flag is 0. Time word fields: seconds [5:0], minutes [11:6], hours [16:12], weekday [19:17] (1 = Sunday … 7 = Saturday), day [24:20], month [28:25] (1 = January). Year register: BCD low two digits [7:0], century BCD [15:8].
- R2: While control bit 26 (offset 0x0C) is 0, strobes leave the time word and the year unchanged.
- R3: While control bit 26 is 1, a strobe makes the seconds field read one higher from the next clock cycle on.
- R4: Seconds wrap 59→0 into minutes, minutes wrap 59→0 into hours, and hours wrap 23→0 into the day. At that day change the weekday steps by one and goes from 7 back to 1.
- R5: The day of month wraps to 1 after day 30 in April, June, September and November, and after day 31 in the other long months. After December 31 the date becomes January 1 of the next year.
- R6: February has 29 days when the year is divisible by 4, except a century year whose century is not divisible by 4. So 2000 and 2024 have February 29, and 2100 does not.
- R7: The year counts in BCD with a decimal carry across all four digits (0x1999→0x2000, 0x2099→0x2100).
- R8: A write to the year load register (0x38) changes only the staged year. The live year (0x30) takes the staged value on the same edge that a write to the time load register (0x08) loads the time word.
- R9: A time-load write in the same cycle as an enabled strobe wins. The counter holds exactly the loaded value, not that value plus one second.
- R10: The alarm flag (bit 0 at offset 0x14, and the `alarm_flag` output) sets one cycle after the time word and year first both equal the time match (0x04) and year match (0x34) registers. A differing weekday prevents the match.
- R11: A write with bit 0 = 1 to offset 0x1C clears the alarm flag. A write there with bit 0 = 0 leaves it set.
- R12: The time match (0x04), year match (0x34), time load (0x08) and year load (0x38) registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_strobe | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| alarm_flag | output | 1 | Raw alarm flag |

## Verification
On every cycle the checker enforces the following. Time and year hold still when the counter is stopped and no load commits. The year moves only on a strobe or a load. Each enabled second either increments or wraps to zero. The alarm flag rises only after a genuine match and falls after a clear. Correctness of the calendar itself can only be shown by the bench's scenarios: month lengths, leap and century rules, weekday wrap, BCD year carry, load staging and the load-versus-strobe priority are all checked there against values the bench derives on its own.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int WORD_W = 32;
  localparam int YEAR_W = 16;
  localparam int NDIG   = YEAR_W / 4;
  localparam int RUN_BIT = 26;

  typedef struct packed {
    logic [2:0] pad;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_word_t;

  localparam logic [7:0] OFS_TIME   = 8'h00;
  localparam logic [7:0] OFS_TMATCH = 8'h04;
  localparam logic [7:0] OFS_TLOAD  = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_FLAG   = 8'h14;
  localparam logic [7:0] OFS_CLEAR  = 8'h1C;
  localparam logic [7:0] OFS_YEAR   = 8'h30;
  localparam logic [7:0] OFS_YMATCH = 8'h34;
  localparam logic [7:0] OFS_YLOAD  = 8'h38;

  function automatic logic [7:0] bcd_pair_to_bin(input logic [7:0] b);
    return (8'(b[7:4]) * 8'd10) + 8'(b[3:0]);
  endfunction

  function automatic logic leap_year(input logic [15:0] y);
    logic [7:0] yy;
    logic [7:0] cc;
    yy = bcd_pair_to_bin(y[7:0]);
    cc = bcd_pair_to_bin(y[15:8]);
    if (yy == 8'd0) return (cc[1:0] == 2'd0);
    return (yy[1:0] == 2'd0);
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                    return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_word_t         cur_time,
  input  logic [YEAR_W-1:0] cur_year,
  output cal_word_t         nxt_time,
  output logic [YEAR_W-1:0] nxt_year
);

  logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
  logic       day_step, mon_step, year_step;
  logic [4:0] month_len;
  logic [NDIG:0] dig_carry;

  always_comb begin
    month_len = days_in_month(cur_time.mon, leap_year(cur_year));
    sec_wrap  = (cur_time.sec  >= 6'd59);
    min_wrap  = (cur_time.min  >= 6'd59);
    hour_wrap = (cur_time.hour >= 5'd23);
    day_wrap  = (cur_time.mday >= month_len);
    mon_wrap  = (cur_time.mon  >= 4'd12);
    day_step  = sec_wrap & min_wrap & hour_wrap;
    mon_step  = day_step & day_wrap;
    year_step = mon_step & mon_wrap;
  end

  always_comb begin
    nxt_time     = cur_time;
    nxt_time.sec = sec_wrap ? 6'd0 : cur_time.sec + 6'd1;
    if (sec_wrap)
      nxt_time.min = min_wrap ? 6'd0 : cur_time.min + 6'd1;
    if (sec_wrap && min_wrap)
      nxt_time.hour = hour_wrap ? 5'd0 : cur_time.hour + 5'd1;
    if (day_step) begin
      nxt_time.wday = (cur_time.wday >= 3'd7) ? 3'd1 : cur_time.wday + 3'd1;
      nxt_time.mday = day_wrap ? 5'd1 : cur_time.mday + 5'd1;
    end
    if (mon_step)
      nxt_time.mon = mon_wrap ? 4'd1 : cur_time.mon + 4'd1;
  end

  assign dig_carry[0] = year_step;

  for (genvar g = 0; g < NDIG; g++) begin : g_bcd_digit
    logic [3:0] dig;
    assign dig              = cur_year[4*g +: 4];
    assign dig_carry[g+1]   = dig_carry[g] & (dig >= 4'd9);
    assign nxt_year[4*g +: 4] = !dig_carry[g] ? dig :
                                (dig >= 4'd9) ? 4'd0 : dig + 4'd1;
  end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cal_word_t         cur_time,
  input  logic [YEAR_W-1:0] cur_year,
  input  cal_word_t         time_match,
  input  logic [YEAR_W-1:0] year_match,
  input  logic              clr_req,
  output logic              flag,
  output logic              set_evt
);

  logic hit, hit_q, flag_q, flag_d;

  always_comb begin
    hit     = (cur_time == time_match) && (cur_year == year_match);
    set_evt = hit & ~hit_q;
    flag_d  = set_evt | (flag_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q  <= hit;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/cal_bus_regs.sv
module cal_bus_regs
  import cal_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [15:0]     RST_YEAR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  cal_word_t         cur_time,
  input  logic [YEAR_W-1:0] cur_year,
  input  logic              alarm_flag,
  output logic              run_en,
  output cal_word_t         time_match,
  output logic [YEAR_W-1:0] year_match,
  output logic [YEAR_W-1:0] year_stage,
  output cal_word_t         time_load,
  output logic              load_commit,
  output logic              alarm_clr
);

  logic              run_q, run_d;
  cal_word_t         tmatch_q, tmatch_d, tload_q, tload_d;
  logic [YEAR_W-1:0] ymatch_q, ymatch_d, ystage_q, ystage_d;
  logic              wr_tmatch, wr_tload, wr_ctrl, wr_ymatch, wr_yload;

  always_comb begin
    wr_tmatch   = bus_wr && (bus_addr == ADDR_W'(OFS_TMATCH));
    wr_tload    = bus_wr && (bus_addr == ADDR_W'(OFS_TLOAD));
    wr_ctrl     = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_ymatch   = bus_wr && (bus_addr == ADDR_W'(OFS_YMATCH));
    wr_yload    = bus_wr && (bus_addr == ADDR_W'(OFS_YLOAD));
    alarm_clr   = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR)) && bus_wdata[0];
    load_commit = wr_tload;

    run_d    = wr_ctrl   ? bus_wdata[RUN_BIT]      : run_q;
    tmatch_d = wr_tmatch ? cal_word_t'(bus_wdata)  : tmatch_q;
    tload_d  = wr_tload  ? cal_word_t'(bus_wdata)  : tload_q;
    ymatch_d = wr_ymatch ? bus_wdata[YEAR_W-1:0]   : ymatch_q;
    ystage_d = wr_yload  ? bus_wdata[YEAR_W-1:0]   : ystage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      tmatch_q <= '0;
      tload_q  <= '0;
      ymatch_q <= '0;
      ystage_q <= RST_YEAR;
    end else begin
      run_q    <= run_d;
      tmatch_q <= tmatch_d;
      tload_q  <= tload_d;
      ymatch_q <= ymatch_d;
      ystage_q <= ystage_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(OFS_TIME))   bus_rdata = cur_time;
    else if (bus_addr == ADDR_W'(OFS_TMATCH)) bus_rdata = tmatch_q;
    else if (bus_addr == ADDR_W'(OFS_TLOAD))  bus_rdata = tload_q;
    else if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata[RUN_BIT] = run_q;
    else if (bus_addr == ADDR_W'(OFS_FLAG))   bus_rdata[0] = alarm_flag;
    else if (bus_addr == ADDR_W'(OFS_YEAR))   bus_rdata[YEAR_W-1:0] = cur_year;
    else if (bus_addr == ADDR_W'(OFS_YMATCH)) bus_rdata[YEAR_W-1:0] = ymatch_q;
    else if (bus_addr == ADDR_W'(OFS_YLOAD))  bus_rdata[YEAR_W-1:0] = ystage_q;
  end

  assign run_en     = run_q;
  assign time_match = tmatch_q;
  assign year_match = ymatch_q;
  assign year_stage = ystage_q;
  assign time_load  = cal_word_t'(bus_wdata);

endmodule

// File: rtl/packed_calendar_clock.sv
module packed_calendar_clock
  import cal_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [15:0] RST_YEAR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_strobe,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              alarm_flag
);

  localparam logic [WORD_W-1:0] RST_TIME =
    {3'd0, 4'd1, 5'd1, 3'd7, 5'd0, 6'd0, 6'd0};

  cal_word_t         time_q, time_d, adv_time, time_match, load_word;
  logic [YEAR_W-1:0] year_q, year_d, adv_year, year_match, year_stage;
  logic              ctrl_en, load_commit, alarm_clr, alarm_set;

  cal_bus_regs #(.ADDR_W(ADDR_W), .RST_YEAR(RST_YEAR)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cur_time    (time_q),
    .cur_year    (year_q),
    .alarm_flag  (alarm_flag),
    .run_en      (ctrl_en),
    .time_match  (time_match),
    .year_match  (year_match),
    .year_stage  (year_stage),
    .time_load   (load_word),
    .load_commit (load_commit),
    .alarm_clr   (alarm_clr)
  );

  cal_advance i_adv (
    .cur_time (time_q),
    .cur_year (year_q),
    .nxt_time (adv_time),
    .nxt_year (adv_year)
  );

  always_comb begin
    time_d = time_q;
    year_d = year_q;
    if (load_commit) begin
      time_d = load_word;
      year_d = year_stage;
    end else if (ctrl_en && sec_strobe) begin
      time_d = adv_time;
      year_d = adv_year;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= cal_word_t'(RST_TIME);
      year_q <= RST_YEAR;
    end else begin
      time_q <= time_d;
      year_q <= year_d;
    end
  end

  cal_alarm i_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_time   (time_q),
    .cur_year   (year_q),
    .time_match (time_match),
    .year_match (year_match),
    .clr_req    (alarm_clr),
    .flag       (alarm_flag),
    .set_evt    (alarm_set)
  );

endmodule

// File: rtl/packed_calendar_clock_chk.sv
module packed_calendar_clock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_strobe,
  input logic        ctrl_en,
  input logic        load_commit,
  input logic [31:0] time_q,
  input logic [15:0] year_q,
  input logic [31:0] time_match,
  input logic [15:0] year_match,
  input logic        alarm_clr,
  input logic        alarm_set,
  input logic        alarm_flag
);

  // R2: stopped counter without a load keeps time and year
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !load_commit) |=> ($stable(time_q) && $stable(year_q)));

  // R3: an enabled second below 59 steps by exactly one
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && sec_strobe && !load_commit && time_q[5:0] < 6'd59)
      |=> (time_q[5:0] == $past(time_q[5:0]) + 6'd1));

  // R4: second 59 wraps to zero
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && sec_strobe && !load_commit && time_q[5:0] == 6'd59)
      |=> (time_q[5:0] == 6'd0));

  // R8: year moves only through a strobe or a committed load
  a_r8_year_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_commit && !(ctrl_en && sec_strobe)) |=> $stable(year_q));

  // R10: the flag rises only after the live pair equalled the match pair
  a_r10_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(time_q) == $past(time_match)
                           && $past(year_q) == $past(year_match)));

  // R11: a clear without a concurrent new match drops the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr && !alarm_set) |=> !alarm_flag);

endmodule

bind packed_calendar_clock packed_calendar_clock_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_strobe  (sec_strobe),
  .ctrl_en     (ctrl_en),
  .load_commit (load_commit),
  .time_q      (time_q),
  .year_q      (year_q),
  .time_match  (time_match),
  .year_match  (year_match),
  .alarm_clr   (alarm_clr),
  .alarm_set   (alarm_set),
  .alarm_flag  (alarm_flag)
);

// File: tb/test_packed_calendar_clock.sv
`timescale 1ns/100ps
module test_packed_calendar_clock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_strobe = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  packed_calendar_clock i_packed_calendar_clock (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_strobe (sec_strobe),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .alarm_flag (alarm_flag)
  );

  localparam logic [31:0] RUN = 32'h0400_0000;

  function automatic logic [31:0] pk(int mo, int md, int wd, int hr, int mi, int sc);
    return {3'd0, 4'(mo), 5'(md), 3'(wd), 5'(hr), 6'(mi), 6'(sc)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_strobe = 1'b1;
    @(negedge clk);
    sec_strobe = 1'b0;
  endtask

  task automatic set_time(logic [15:0] y, logic [31:0] t);
    wr(8'h38, {16'd0, y});
    wr(8'h08, t);
  endtask

  task automatic tick_and_check(string tag, logic [31:0] t_exp, logic [15:0] y_exp);
    logic [31:0] v;
    tick();
    rd(8'h00, v); check({tag, " time"}, v, t_exp);
    rd(8'h30, v); check({tag, " year"}, v, {16'd0, y_exp});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 reset time", v, 32'h021E_0000);
    rd(8'h30, v); check("R1 reset year", v, 32'h0000_2000);
    rd(8'h0C, v); check("R1 reset ctrl", v, 32'h0);
    rd(8'h14, v); check("R1 reset flag", v, 32'h0);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    tick(); tick();
    rd(8'h00, v); check("R2 stopped time", v, 32'h021E_0000);
    rd(8'h30, v); check("R2 stopped year", v, 32'h0000_2000);
  endtask

  task automatic t_run();
    wr(8'h0C, RUN);
    tick_and_check("R3 first second", pk(1, 1, 7, 0, 0, 1), 16'h2000);
    tick_and_check("R3 second step", pk(1, 1, 7, 0, 0, 2), 16'h2000);
  endtask

  task automatic t_day_roll();
    set_time(16'h2000, pk(1, 1, 7, 0, 0, 59));
    tick_and_check("R4 sec to min", pk(1, 1, 7, 0, 1, 0), 16'h2000);
    set_time(16'h2000, pk(1, 1, 7, 0, 59, 59));
    tick_and_check("R4 min to hour", pk(1, 1, 7, 1, 0, 0), 16'h2000);
    set_time(16'h2000, pk(1, 1, 7, 23, 59, 59));
    tick_and_check("R4 midnight wday 7->1", pk(1, 2, 1, 0, 0, 0), 16'h2000);
    set_time(16'h2000, pk(1, 2, 1, 23, 59, 59));
    tick_and_check("R4 wday 1->2", pk(1, 3, 2, 0, 0, 0), 16'h2000);
  endtask

  task automatic t_month_len();
    set_time(16'h2023, pk(4, 30, 3, 23, 59, 59));
    tick_and_check("R5 april 30", pk(5, 1, 4, 0, 0, 0), 16'h2023);
    set_time(16'h2023, pk(5, 30, 3, 23, 59, 59));
    tick_and_check("R5 may 30", pk(5, 31, 4, 0, 0, 0), 16'h2023);
    set_time(16'h2023, pk(11, 30, 5, 23, 59, 59));
    tick_and_check("R5 nov 30", pk(12, 1, 6, 0, 0, 0), 16'h2023);
    set_time(16'h2023, pk(12, 31, 1, 23, 59, 59));
    tick_and_check("R5 new year", pk(1, 1, 2, 0, 0, 0), 16'h2024);
  endtask

  task automatic t_leap();
    set_time(16'h2000, pk(2, 28, 2, 23, 59, 59));
    tick_and_check("R6 2000 feb 28", pk(2, 29, 3, 0, 0, 0), 16'h2000);
    set_time(16'h2000, pk(2, 29, 3, 23, 59, 59));
    tick_and_check("R6 2000 feb 29", pk(3, 1, 4, 0, 0, 0), 16'h2000);
    set_time(16'h2100, pk(2, 28, 1, 23, 59, 59));
    tick_and_check("R6 2100 feb 28", pk(3, 1, 2, 0, 0, 0), 16'h2100);
    set_time(16'h2024, pk(2, 28, 4, 23, 59, 59));
    tick_and_check("R6 2024 feb 28", pk(2, 29, 5, 0, 0, 0), 16'h2024);
    set_time(16'h2023, pk(2, 28, 3, 23, 59, 59));
    tick_and_check("R6 2023 feb 28", pk(3, 1, 4, 0, 0, 0), 16'h2023);
  endtask

  task automatic t_year_carry();
    set_time(16'h1999, pk(12, 31, 6, 23, 59, 59));
    tick_and_check("R7 1999 to 2000", pk(1, 1, 7, 0, 0, 0), 16'h2000);
    set_time(16'h2099, pk(12, 31, 5, 23, 59, 59));
    tick_and_check("R7 2099 to 2100", pk(1, 1, 6, 0, 0, 0), 16'h2100);
    set_time(16'h2009, pk(12, 31, 5, 23, 59, 59));
    tick_and_check("R7 2009 to 2010", pk(1, 1, 6, 0, 0, 0), 16'h2010);
  endtask

  task automatic t_load_staging();
    logic [31:0] v;
    wr(8'h0C, 32'h0);
    set_time(16'h2005, pk(6, 6, 2, 6, 6, 6));
    wr(8'h38, 32'h0000_2031);
    rd(8'h30, v); check("R8 year staged only", v, 32'h0000_2005);
    rd(8'h00, v); check("R8 time unchanged", v, pk(6, 6, 2, 6, 6, 6));
    wr(8'h08, pk(7, 4, 6, 12, 0, 0));
    rd(8'h30, v); check("R8 year committed", v, 32'h0000_2031);
    rd(8'h00, v); check("R8 time committed", v, pk(7, 4, 6, 12, 0, 0));
  endtask

  task automatic t_load_priority();
    logic [31:0] v;
    wr(8'h0C, RUN);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = pk(3, 3, 3, 3, 3, 3);
    sec_strobe = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_strobe = 1'b0;
    rd(8'h00, v); check("R9 load beats strobe", v, pk(3, 3, 3, 3, 3, 3));
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h04, pk(9, 9, 4, 9, 9, 9));
    wr(8'h34, 32'h0000_2077);
    wr(8'h38, 32'h0000_2042);
    rd(8'h04, v); check("R12 time match", v, pk(9, 9, 4, 9, 9, 9));
    rd(8'h34, v); check("R12 year match", v, 32'h0000_2077);
    rd(8'h38, v); check("R12 year load", v, 32'h0000_2042);
    rd(8'h08, v); check("R12 time load", v, pk(3, 3, 3, 3, 3, 3));
  endtask

  task automatic t_alarm_and_clear();
    logic [31:0] v;
    wr(8'h0C, 32'h0);
    wr(8'h04, pk(8, 15, 3, 10, 20, 31));
    wr(8'h34, 32'h0000_2041);
    // wrong weekday: same date and time, no match
    set_time(16'h2041, pk(8, 15, 4, 10, 20, 31));
    rd(8'h14, v); check("R10 weekday differs no flag", v, 32'h0);
    check("R10 weekday differs pin", {31'd0, alarm_flag}, 32'h0);
    wr(8'h0C, RUN);
    set_time(16'h2041, pk(8, 15, 3, 10, 20, 30));
    rd(8'h14, v); check("R10 before match", v, 32'h0);
    tick();
    rd(8'h14, v); check("R10 flag on match", v, 32'h1);
    check("R10 flag pin", {31'd0, alarm_flag}, 32'h1);
    wr(8'h1C, 32'h0);
    rd(8'h14, v); check("R11 zero write keeps flag", v, 32'h1);
    wr(8'h1C, 32'h1);
    rd(8'h14, v); check("R11 clear drops flag", v, 32'h0);
    check("R11 pin cleared", {31'd0, alarm_flag}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_run();
    t_day_roll();
    t_month_len();
    t_leap();
    t_year_carry();
    t_load_staging();
    t_load_priority();
    t_readback();
    t_alarm_and_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule